// File: doc/BRIEF.md
# Speculative Critical-Section Conflict Tracker

This block follows the memory footprint of lock-free speculative critical sections run by several hardware thread contexts that share one small L1 cache. For every cache line and every thread it keeps two flags. One flag records that the thread loaded from the line while speculating. The other records that the thread stored to it. Coherence snoops from other agents and cache evictions are compared against these flags. When a thread's speculation can no longer be proven safe, the block aborts that thread.

An abort does three things. It raises a one-cycle pulse that asks the core to restore its register checkpoint. It streams out the indices of every line the thread stored to speculatively, so the cache can drop them, and then it pulses a done signal. Finally it flash-clears the thread's flags. A commit clears the flags at once.

Each thread counts its consecutive aborts. Once the limit is reached, the thread is pushed back to taking the lock for real. Further speculation requests from that thread are refused until software reports a non-speculative lock release.

Top module: `slt_conflict_tracker`

## Requirements
- R1: Lines are 64 bytes and the tracker holds 64 lines for 4 threads. The line index is address bits [11:6], so addresses that differ only in bits [5:0] or above bit 11 map to the same line.
- R2: After reset no thread is speculating and no flag, abort, fallback or stream output is set. A begin pulse for a thread that is idle and not in fallback makes its `active_o` bit 1 after the next clock edge.
- R3: While a thread is active, a local load sets that thread's read flag for the line and a local store sets its write flag. Accesses tagged with a thread that is not active leave no trace.
- R4: A remote read conflicts only with a line in a thread's write set. A remote read of a line the thread only loaded does not abort it.
- R5: A remote write or invalidate (`snp_write_i`=1) conflicts with a line that has either flag set.
- R6: A conflict on edge N sets the thread's `abort_o` bit for exactly the cycle after edge N, and the thread's `active_o` bit is 0 from that same cycle.
- R7: An eviction of a line that an active thread has either flag set on aborts that thread.
- R8: After an abort, the written lines of the thread are presented one per cycle on `inv_line_o` with `inv_valid_o`, in ascending index order, with `inv_tid_o` naming the thread. A single `inv_done_o` pulse follows. A thread with an empty write set produces only the done pulse.
- R9: A commit ends speculation and clears all flags of the thread at once, so a later snoop to a previously tracked line does not abort a new speculation.
- R10: The third consecutive abort of a thread sets its `fallback_o` bit, and begin pulses are refused while it is set. A commit resets the consecutive-abort count.
- R11: A `release_i` pulse for a thread clears its fallback bit and its abort count, after which begin is accepted again.
- R12: When several threads abort together, their invalidate streams are served one thread at a time, the lowest thread index first.
- R13: A conflict in the same cycle as a commit of that thread wins, and the thread aborts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| begin_i | input | 4 | Per-thread request to start speculation |
| commit_i | input | 4 | Per-thread end of critical section with success |
| release_i | input | 4 | Per-thread non-speculative lock release |
| acc_valid_i | input | 1 | Local access valid |
| acc_tid_i | input | 2 | Thread issuing the local access |
| acc_write_i | input | 1 | Local access is a store |
| acc_addr_i | input | 32 | Local access byte address |
| snp_valid_i | input | 1 | Remote snoop valid |
| snp_write_i | input | 1 | Snoop is write/invalidate (1) or read (0) |
| snp_addr_i | input | 32 | Snoop byte address |
| evict_valid_i | input | 1 | Cache is evicting a line |
| evict_addr_i | input | 32 | Byte address of evicted line |
| active_o | output | 4 | Thread is speculating |
| fallback_o | output | 4 | Thread must take the lock non-speculatively |
| abort_o | output | 4 | One-cycle abort and checkpoint restore request |
| inv_valid_o | output | 1 | Invalidate-list entry valid |
| inv_line_o | output | 6 | Line index to invalidate |
| inv_tid_o | output | 2 | Thread whose abort is being streamed |
| inv_done_o | output | 1 | End of invalidate list |

## Verification
Snoops are issued against lines that were only read, lines that were written, and untouched lines. This separates the read-only rule from the write/invalidate rule and exposes any conflict raised on the wrong flag. Addresses with different offset bits and different upper bits probe the line mapping. Several written lines per thread, an empty write set, and two threads aborted on the same edge show the ordering of the invalidate stream within a thread and across threads. Repeated aborts with and without an intervening commit, and a commit that collides with a conflict, show the fallback counter and the abort priority.

// File: rtl/slt_pkg.sv
package slt_pkg;
  localparam int unsigned DEF_LINES   = 64;
  localparam int unsigned DEF_THREADS = 4;
  localparam int unsigned DEF_ADDR_W  = 32;
  localparam int unsigned DEF_OFF_W   = 6;
  localparam int unsigned DEF_LIMIT   = 3;

  typedef enum logic {
    SNP_READ  = 1'b0,
    SNP_INVAL = 1'b1
  } snp_kind_e;
endpackage

// File: rtl/slt_thread_ctl.sv
module slt_thread_ctl
  import slt_pkg::*;
#(
  parameter int unsigned LINES = DEF_LINES,
  parameter int unsigned LIMIT = DEF_LIMIT,
  localparam int unsigned LINE_W = $clog2(LINES),
  localparam int unsigned CNT_W  = $clog2(LIMIT + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              begin_i,
  input  logic              commit_i,
  input  logic              release_i,
  input  logic              acc_hit_i,
  input  logic              acc_write_i,
  input  logic [LINE_W-1:0] acc_line_i,
  input  logic              snp_valid_i,
  input  snp_kind_e         snp_kind_i,
  input  logic [LINE_W-1:0] snp_line_i,
  input  logic              evict_valid_i,
  input  logic [LINE_W-1:0] evict_line_i,
  input  logic              sel_i,
  input  logic              clear_i,
  output logic              spec_o,
  output logic              pend_o,
  output logic              fallback_o,
  output logic              abort_o,
  output logic [LINES-1:0]  wr_set_o
);
  logic [LINES-1:0] rd_q, wr_q;
  logic             spec_q, hold_q, pend_q, fb_q, abort_q;
  logic [CNT_W-1:0] cnt_q;
  logic             snp_hit, ev_hit, conflict;
  logic [CNT_W-1:0] cnt_inc;

  always_comb begin
    snp_hit = 1'b0;
    if (snp_valid_i) begin
      if (snp_kind_i == SNP_INVAL) snp_hit = rd_q[snp_line_i] | wr_q[snp_line_i];
      else                         snp_hit = wr_q[snp_line_i];
    end
    ev_hit   = evict_valid_i & (rd_q[evict_line_i] | wr_q[evict_line_i]);
    conflict = spec_q & (snp_hit | ev_hit);
    cnt_inc  = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q    <= '0;
      wr_q    <= '0;
      spec_q  <= 1'b0;
      hold_q  <= 1'b0;
      pend_q  <= 1'b0;
      fb_q    <= 1'b0;
      abort_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      abort_q <= 1'b0;
      if (conflict) begin
        // abort wins over commit and local access in the same cycle
        spec_q  <= 1'b0;
        hold_q  <= 1'b1;
        pend_q  <= 1'b1;
        abort_q <= 1'b1;
        cnt_q   <= cnt_inc;
        if (cnt_inc >= CNT_W'(LIMIT)) fb_q <= 1'b1;
      end else if (commit_i && spec_q) begin
        spec_q <= 1'b0;
        rd_q   <= '0;
        wr_q   <= '0;
        cnt_q  <= '0;
      end else if (begin_i && !spec_q && !hold_q && !fb_q) begin
        spec_q <= 1'b1;
      end else if (acc_hit_i && spec_q) begin
        if (acc_write_i) wr_q[acc_line_i] <= 1'b1;
        else             rd_q[acc_line_i] <= 1'b1;
      end
      if (release_i && !spec_q) begin
        fb_q  <= 1'b0;
        cnt_q <= '0;
      end
      if (sel_i) pend_q <= 1'b0;
      if (clear_i) begin
        hold_q <= 1'b0;
        rd_q   <= '0;
        wr_q   <= '0;
      end
    end
  end

  assign spec_o     = spec_q;
  assign pend_o     = pend_q;
  assign fallback_o = fb_q;
  assign abort_o    = abort_q;
  assign wr_set_o   = wr_q;

  p_abort_was_spec_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_q |-> (!spec_q && $past(spec_q)));
  p_ro_read_safe_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spec_q && snp_valid_i && snp_kind_i == SNP_READ && !wr_q[snp_line_i] && !evict_valid_i)
    |=> !abort_q);
  p_fallback_blocks_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fb_q && !release_i) |=> !spec_q);
  p_commit_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && spec_q && !conflict) |=> (rd_q == '0 && wr_q == '0 && !spec_q));
endmodule

// File: rtl/slt_inv_streamer.sv
module slt_inv_streamer #(
  parameter int unsigned LINES   = 64,
  parameter int unsigned THREADS = 4,
  localparam int unsigned LINE_W = $clog2(LINES),
  localparam int unsigned TID_W  = $clog2(THREADS)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [THREADS-1:0]            pend_i,
  input  logic [THREADS-1:0][LINES-1:0] wr_sets_i,
  output logic [THREADS-1:0]            sel_o,
  output logic [THREADS-1:0]            clear_o,
  output logic                          inv_valid_o,
  output logic [LINE_W-1:0]             inv_line_o,
  output logic [TID_W-1:0]              inv_tid_o,
  output logic                          inv_done_o
);
  logic              busy_q;
  logic [TID_W-1:0]  tid_q;
  logic [LINES-1:0]  mask_q;
  logic [TID_W-1:0]  pick;
  logic [LINE_W-1:0] low;

  always_comb begin
    pick = '0;
    for (int i = THREADS - 1; i >= 0; i--)
      if (pend_i[i]) pick = TID_W'(i);
    low = '0;
    for (int i = LINES - 1; i >= 0; i--)
      if (mask_q[i]) low = LINE_W'(i);
  end

  always_comb begin
    sel_o   = '0;
    clear_o = '0;
    if (!busy_q && |pend_i) sel_o[pick] = 1'b1;
    if (busy_q && mask_q == '0) clear_o[tid_q] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      tid_q  <= '0;
      mask_q <= '0;
    end else if (!busy_q) begin
      if (|pend_i) begin
        busy_q <= 1'b1;
        tid_q  <= pick;
        mask_q <= wr_sets_i[pick];
      end
    end else if (mask_q != '0) begin
      mask_q[low] <= 1'b0;
    end else begin
      busy_q <= 1'b0;
    end
  end

  assign inv_valid_o = busy_q && (mask_q != '0);
  assign inv_done_o  = busy_q && (mask_q == '0);
  assign inv_line_o  = low;
  assign inv_tid_o   = tid_q;

  p_ascending_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_valid_o |=> (inv_done_o || (inv_line_o > $past(inv_line_o))));
  p_done_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_done_o |=> !inv_done_o && !inv_valid_o);
  p_tid_held_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_valid_o |=> $stable(inv_tid_o));
  p_sel_onehot_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_o));
endmodule

// File: rtl/slt_conflict_tracker.sv
module slt_conflict_tracker
  import slt_pkg::*;
#(
  parameter int unsigned LINES   = DEF_LINES,
  parameter int unsigned THREADS = DEF_THREADS,
  parameter int unsigned ADDR_W  = DEF_ADDR_W,
  parameter int unsigned OFF_W   = DEF_OFF_W,
  parameter int unsigned LIMIT   = DEF_LIMIT,
  localparam int unsigned LINE_W = $clog2(LINES),
  localparam int unsigned TID_W  = $clog2(THREADS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [THREADS-1:0] begin_i,
  input  logic [THREADS-1:0] commit_i,
  input  logic [THREADS-1:0] release_i,
  input  logic               acc_valid_i,
  input  logic [TID_W-1:0]   acc_tid_i,
  input  logic               acc_write_i,
  input  logic [ADDR_W-1:0]  acc_addr_i,
  input  logic               snp_valid_i,
  input  logic               snp_write_i,
  input  logic [ADDR_W-1:0]  snp_addr_i,
  input  logic               evict_valid_i,
  input  logic [ADDR_W-1:0]  evict_addr_i,
  output logic [THREADS-1:0] active_o,
  output logic [THREADS-1:0] fallback_o,
  output logic [THREADS-1:0] abort_o,
  output logic               inv_valid_o,
  output logic [LINE_W-1:0]  inv_line_o,
  output logic [TID_W-1:0]   inv_tid_o,
  output logic               inv_done_o
);
  logic [LINE_W-1:0] acc_line, snp_line, ev_line;
  snp_kind_e         snp_kind;
  logic [THREADS-1:0] pend, sel, clr;
  logic [THREADS-1:0][LINES-1:0] wr_sets;
  logic unused_addr_bits;

  assign acc_line = acc_addr_i[OFF_W +: LINE_W];
  assign snp_line = snp_addr_i[OFF_W +: LINE_W];
  assign ev_line  = evict_addr_i[OFF_W +: LINE_W];
  assign snp_kind = snp_write_i ? SNP_INVAL : SNP_READ;
  assign unused_addr_bits = ^{acc_addr_i, snp_addr_i, evict_addr_i};

  for (genvar t = 0; t < THREADS; t++) begin : g_thr
    slt_thread_ctl #(.LINES(LINES), .LIMIT(LIMIT)) u_thr (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .begin_i      (begin_i[t]),
      .commit_i     (commit_i[t]),
      .release_i    (release_i[t]),
      .acc_hit_i    (acc_valid_i && (acc_tid_i == TID_W'(t))),
      .acc_write_i  (acc_write_i),
      .acc_line_i   (acc_line),
      .snp_valid_i  (snp_valid_i),
      .snp_kind_i   (snp_kind),
      .snp_line_i   (snp_line),
      .evict_valid_i(evict_valid_i),
      .evict_line_i (ev_line),
      .sel_i        (sel[t]),
      .clear_i      (clr[t]),
      .spec_o       (active_o[t]),
      .pend_o       (pend[t]),
      .fallback_o   (fallback_o[t]),
      .abort_o      (abort_o[t]),
      .wr_set_o     (wr_sets[t])
    );
  end

  slt_inv_streamer #(.LINES(LINES), .THREADS(THREADS)) u_stream (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pend_i     (pend),
    .wr_sets_i  (wr_sets),
    .sel_o      (sel),
    .clear_o    (clr),
    .inv_valid_o(inv_valid_o),
    .inv_line_o (inv_line_o),
    .inv_tid_o  (inv_tid_o),
    .inv_done_o (inv_done_o)
  );

  p_stream_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(inv_valid_o && inv_done_o));
endmodule

// File: tb/tb_slt_conflict_tracker.sv
module tb_slt_conflict_tracker;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] begin_v = '0, commit_v = '0, release_v = '0;
  logic       acc_valid = 1'b0, acc_write = 1'b0;
  logic [1:0] acc_tid = '0;
  logic [31:0] acc_addr = '0, snp_addr = '0, evict_addr = '0;
  logic       snp_valid = 1'b0, snp_write = 1'b0, evict_valid = 1'b0;
  logic [3:0] active, fallback, abort_v;
  logic       inv_valid, inv_done;
  logic [5:0] inv_line;
  logic [1:0] inv_tid;

  always #(CLK_PERIOD / 2) clk = ~clk;

  slt_conflict_tracker dut (
    .clk_i(clk), .rst_ni(rst_n),
    .begin_i(begin_v), .commit_i(commit_v), .release_i(release_v),
    .acc_valid_i(acc_valid), .acc_tid_i(acc_tid), .acc_write_i(acc_write), .acc_addr_i(acc_addr),
    .snp_valid_i(snp_valid), .snp_write_i(snp_write), .snp_addr_i(snp_addr),
    .evict_valid_i(evict_valid), .evict_addr_i(evict_addr),
    .active_o(active), .fallback_o(fallback), .abort_o(abort_v),
    .inv_valid_o(inv_valid), .inv_line_o(inv_line), .inv_tid_o(inv_tid), .inv_done_o(inv_done)
  );

  typedef struct packed { logic done; logic [1:0] tid; logic [5:0] line; } exp_t;
  exp_t exp_q[$];
  int n_vec = 0;
  int n_bad = 0;

  task automatic chk(input string rq, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic exp_line(input int tid, input int line);
    exp_q.push_back('{done: 1'b0, tid: 2'(tid), line: 6'(line)});
  endtask

  task automatic exp_done(input int tid);
    exp_q.push_back('{done: 1'b1, tid: 2'(tid), line: 6'd0});
  endtask

  // scoreboard monitor for the invalidate stream (R8, R12)
  always @(negedge clk) begin
    if (rst_n && (inv_valid || inv_done)) begin
      n_vec++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R8: unexpected stream item done=%0d tid=%0d line=%0d", inv_done, inv_tid, inv_line);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (e.done != inv_done || e.tid != inv_tid || (!e.done && e.line != inv_line)) begin
          n_bad++;
          $display("FAIL R8/R12: actual done=%0d tid=%0d line=%0d expected done=%0d tid=%0d line=%0d",
                   inv_done, inv_tid, inv_line, e.done, e.tid, e.line);
        end
      end
    end
  end

  task automatic do_begin(input int t);
    begin_v[t] = 1'b1; tick(); begin_v = '0;
  endtask

  task automatic access(input int t, input logic wr, input logic [31:0] a);
    acc_valid = 1'b1; acc_tid = 2'(t); acc_write = wr; acc_addr = a;
    tick(); acc_valid = 1'b0;
  endtask

  task automatic snoop(input logic wr, input logic [31:0] a);
    snp_valid = 1'b1; snp_write = wr; snp_addr = a;
    tick(); snp_valid = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 200 && exp_q.size() != 0; i++) tick();
    tick();
    chk("R8 stream drained", exp_q.size(), 0);
  endtask

  function automatic logic [31:0] la(input int line, input int hi, input int off);
    return (32'(hi) << 12) | (32'(line) << 6) | 32'(off);
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    tick(); tick();
    chk("R2 reset active", active, 0);
    chk("R2 reset fallback", fallback, 0);
    chk("R2 reset abort", abort_v, 0);
    chk("R2 reset stream", {inv_valid, inv_done}, 0);
    rst_n = 1'b1;
    tick();

    // R2 begin, R3 tracking, R1 aliasing
    do_begin(0);
    chk("R2 begin accepted", active, 4'b0001);
    access(0, 1'b0, la(5, 0, 3));
    access(0, 1'b1, la(9, 0, 0));
    access(0, 1'b1, la(2, 1, 63));   // line 2 through upper-bit alias (R1)
    access(1, 1'b1, la(50, 0, 0));   // thread 1 idle: ignored (R3)
    // R4: read of read-only line is safe
    snoop(1'b0, la(5, 7, 10));
    chk("R4 read vs read-only line", abort_v, 0);
    chk("R4 still active", active, 4'b0001);
    // R4: read of written line conflicts; R6 timing
    exp_line(0, 2); exp_line(0, 9); exp_done(0);
    snoop(1'b0, la(9, 3, 1));
    chk("R6 abort pulse", abort_v, 4'b0001);
    chk("R6 left speculation", active, 0);
    tick();
    chk("R6 pulse one cycle", abort_v, 0);
    drain();

    // R3 ignore check: thread 1 now speculates, line 50 must be clean
    do_begin(1);
    snoop(1'b0, la(50, 0, 0));
    chk("R3 idle access left no flag", abort_v, 0);
    // R5: write snoop against read-only line
    access(1, 1'b0, la(7, 0, 0));
    exp_done(1);
    snoop(1'b1, la(7, 2, 33));
    chk("R5 inval vs read line", abort_v, 4'b0010);
    drain();

    // R7 eviction
    do_begin(2);
    access(2, 1'b1, la(63, 0, 0));
    exp_line(2, 63); exp_done(2);
    evict_valid = 1'b1; evict_addr = la(63, 0, 0); tick(); evict_valid = 1'b0;
    chk("R7 evict aborts", abort_v, 4'b0100);
    drain();

    // R12 two threads abort together
    do_begin(0); do_begin(3);
    access(0, 1'b1, la(10, 0, 0));
    access(3, 1'b0, la(10, 0, 0));
    access(3, 1'b1, la(4, 0, 0));
    access(3, 1'b1, la(1, 0, 0));
    exp_line(0, 10); exp_done(0); exp_line(3, 1); exp_line(3, 4); exp_done(3);
    snoop(1'b1, la(10, 0, 0));
    chk("R12 joint abort", abort_v, 4'b1001);
    drain();

    // R9 commit flash clear
    do_begin(1);
    access(1, 1'b1, la(20, 0, 0));
    commit_v[1] = 1'b1; tick(); commit_v = '0;
    chk("R9 commit ends spec", active, 0);
    do_begin(1);
    snoop(1'b1, la(20, 0, 0));
    chk("R9 flags cleared", abort_v, 0);
    commit_v[1] = 1'b1; tick(); commit_v = '0;

    // R10 third consecutive abort of thread 0
    do_begin(0);
    access(0, 1'b1, la(30, 0, 0));
    exp_line(0, 30); exp_done(0);
    snoop(1'b1, la(30, 0, 0));
    chk("R10 fallback set", fallback, 4'b0001);
    drain();
    do_begin(0);
    chk("R10 begin refused", active, 0);

    // R11 release
    release_v[0] = 1'b1; tick(); release_v = '0;
    chk("R11 fallback cleared", fallback, 0);
    do_begin(0);
    chk("R11 begin accepted", active, 4'b0001);

    // R13 conflict beats commit
    access(0, 1'b1, la(40, 0, 0));
    exp_line(0, 40); exp_done(0);
    commit_v[0] = 1'b1; snp_valid = 1'b1; snp_write = 1'b1; snp_addr = la(40, 0, 0);
    tick(); commit_v = '0; snp_valid = 1'b0;
    chk("R13 abort wins", abort_v, 4'b0001);
    drain();

    // R10 commit reset the count of thread 1 (one abort before commit)
    for (int k = 0; k < 2; k++) begin
      do_begin(1);
      access(1, 1'b0, la(3, 0, 0));
      exp_done(1);
      snoop(1'b1, la(3, 0, 0));
      drain();
    end
    chk("R10 commit reset count", fallback, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule